// File: doc/BRIEF.md
# Wake and Power-Good Controller

This block sits between the bus reset, the auxiliary power-good signal and the wake sources of a network controller. It decides four things: whether a bus reset actually resets the internal logic, when the bus pins are asked to float, when a power-management event is requested, and how the remote wake pin is driven. When power-good is low, the controller is running from auxiliary power. A bus reset then only floats the bus pins and leaves the internal state alone, and the controller may enter magic-packet mode.

Wake sources arrive as one-cycle strobes, one for a magic-packet match and one for a link change. The block holds each strobe in a sticky flag until software clears it with a write-one-to-clear pulse. The remote wake pin has configurable polarity, drive type and gating by power-good. It stays undriven from power-on until its configuration has been loaded.

A four-state machine orders the reset and configuration load. `ST_LOAD` is entered at power-on and after a logic reset, and it holds the load request. `ST_RUN` is normal operation. `ST_RESET` holds the internal reset. `ST_ISOLATE` covers a bus reset that arrives while power-good is low. Its transitions are:
- LOAD_DONE: `ST_LOAD`→`ST_RUN` on the load-done pulse.
- LOAD_HIT: `ST_LOAD`→`ST_RESET` on a reset with power-good high.
- RUN_HIT: `ST_RUN`→`ST_RESET` on a reset with power-good high.
- RUN_AUX: `ST_RUN`→`ST_ISOLATE` on a reset with power-good low.
- ISO_END: `ST_ISOLATE`→`ST_RUN` when the reset is released.
- ISO_PWR: `ST_ISOLATE`→`ST_RESET` when power-good rises while the reset is still held.
- RST_END: `ST_RESET`→`ST_LOAD` when the reset is released or power-good falls.

Top module: `wake_pwr_ctl`

## Requirements
- R1: `pme_req` is 1 exactly when (`pme_status` and `pme_en`) or (`pme_ovr` and the magic flag) or (`pme_ovr` and the link flag).
- R2: A 1 on `mp_hit` (`lc_hit`) sets the magic (link) flag at the next clock edge. A 1 on `mp_w1c` (`lc_w1c`) clears it. A set and a clear in the same cycle leave the flag set. The internal reset also clears both flags.
- R3: Magic-packet mode is active when `pwr_good` is 0 and either `mp_en` or `mp_mode` is 1. `wake_ind` is 1 (pull the open-drain line low) exactly while magic-packet mode is active.
- R4: With `pwr_good` 1, a low `pci_rst_n` raises `int_rst` at the third clock edge after it is sampled. `int_rst` stays 1 while the reset is held and clears both flags. After release, `ee_load` is 1 from the third edge until a `cfg_done` pulse.
- R5: With `pwr_good` 0, a low `pci_rst_n` never raises `int_rst` and leaves both flags and `pme_req` unchanged.
- R6: `pci_hiz` is the synchronized reset, 1 from the second clock edge after `pci_rst_n` is sampled low and 0 from the second edge after it is sampled high, whatever the level of `pwr_good`.
- R7: The remote wake is active when (magic-packet mode and the magic flag) or (`lcd_mode` and the link flag).
- R8: `rwake_o` equals the active state when `rwake_pol` is 1 and its inverse when `rwake_pol` is 0.
- R9: When `rwake_gate` is 1 and `pwr_good` is 0, `rwake_oe` is 0.
- R10: With `rwake_totem` 1, `rwake_oe` is 1 and `rwake_od` is 0. With `rwake_totem` 0, `rwake_od` is 1 and `rwake_oe` is 1 only while `rwake_o` is 0. Gating (R9) and the rule in R11 override this.
- R11: From power-on reset until the first `cfg_done` pulse, `rwake_oe` is 0. A later bus reset does not bring this condition back.
- R12: A rise of `pwr_good` while the bus reset is held enters the internal reset at the next edge. A fall of `pwr_good` during the internal reset leaves it for the load state at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| pci_rst_n | input | 1 | Bus reset, active low, asynchronous to clk |
| pwr_good | input | 1 | Main power present, synchronous to clk |
| mp_hit | input | 1 | One-cycle magic-packet match strobe |
| lc_hit | input | 1 | One-cycle link-change strobe |
| mp_w1c | input | 1 | Software clear of the magic flag |
| lc_w1c | input | 1 | Software clear of the link flag |
| cfg_done | input | 1 | Configuration load finished pulse |
| pme_status | input | 1 | Power-management status bit |
| pme_en | input | 1 | Power-management enable bit |
| pme_ovr | input | 1 | Enable override for event requests |
| mp_en | input | 1 | Magic-packet enable bit |
| mp_mode | input | 1 | Magic-packet mode bit |
| lcd_mode | input | 1 | Link-change-detect mode bit |
| rwake_pol | input | 1 | Remote wake polarity, 1 = active high |
| rwake_gate | input | 1 | Float remote wake while power-good is low |
| rwake_totem | input | 1 | 1 = totem-pole, 0 = open-drain |
| pme_req | output | 1 | Power-management event request |
| rwake_o | output | 1 | Remote wake pin level |
| rwake_oe | output | 1 | Remote wake output enable |
| rwake_od | output | 1 | Remote wake is in open-drain mode |
| wake_ind | output | 1 | Wake-mode indicator, 1 = pull line low |
| int_rst | output | 1 | Internal logic reset |
| ee_load | output | 1 | Configuration load request |
| pci_hiz | output | 1 | Request to float bus pins |

## Verification
The hardest situations to reach are the two power-good edges that happen while the bus reset is already held: power-good rising in `ST_ISOLATE`, and power-good falling in `ST_RESET`. The stimulus holds the reset low with power-good low until the isolate state is settled. It then raises power-good and checks the internal reset one edge later. Next it drops power-good and checks that the load request appears, before the reset is ever released. The same run latches a magic flag before the reset, so that its survival under auxiliary power shows up at `pme_req`.

// File: rtl/wk_pkg.sv
package wk_pkg;

    typedef enum logic [1:0] {
        ST_LOAD    = 2'd0,
        ST_RUN     = 2'd1,
        ST_RESET   = 2'd2,
        ST_ISOLATE = 2'd3
    } wk_state_e;

    localparam int WK_FLAG_MAGIC = 0;
    localparam int WK_FLAG_LINK  = 1;
    localparam int WK_NUM_FLAGS  = 2;

endpackage

// File: rtl/wk_rst_sync.sv
module wk_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic pin_n,
    output logic rst_s
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES < 2) begin : g_bad
            initial $error("wk_rst_sync needs at least two stages");
        end
    endgenerate

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], ~pin_n};
        end
    end

    assign rst_s = chain_q[LAST];
endmodule

// File: rtl/wk_mode_fsm.sv
module wk_mode_fsm
    import wk_pkg::*;
(
    input  logic      clk,
    input  logic      por_n,
    input  logic      rst_s,
    input  logic      pwr_good,
    input  logic      cfg_done,
    output wk_state_e state,
    output logic      int_rst,
    output logic      ee_load
);
    wk_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD: begin
                if (rst_s && pwr_good)      state_d = ST_RESET;   // LOAD_HIT
                else if (cfg_done)          state_d = ST_RUN;     // LOAD_DONE
            end
            ST_RUN: begin
                if (rst_s && pwr_good)      state_d = ST_RESET;   // RUN_HIT
                else if (rst_s)             state_d = ST_ISOLATE; // RUN_AUX
            end
            ST_RESET: begin
                if (!rst_s || !pwr_good)    state_d = ST_LOAD;    // RST_END
            end
            ST_ISOLATE: begin
                if (!rst_s)                 state_d = ST_RUN;     // ISO_END
                else if (pwr_good)          state_d = ST_RESET;   // ISO_PWR
            end
            default:                        state_d = ST_LOAD;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= ST_LOAD;
        else        state_q <= state_d;
    end

    always_comb begin
        int_rst = 1'b0;
        ee_load = 1'b0;
        unique case (state_q)
            ST_LOAD:    ee_load = 1'b1;
            ST_RESET:   int_rst = 1'b1;
            ST_RUN,
            ST_ISOLATE: ;
            default:    ;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/wk_wake_flags.sv
module wk_wake_flags
    import wk_pkg::*;
(
    input  logic                    clk,
    input  logic                    por_n,
    input  logic                    clr_all,
    input  logic [WK_NUM_FLAGS-1:0] hit,
    input  logic [WK_NUM_FLAGS-1:0] w1c,
    output logic [WK_NUM_FLAGS-1:0] flag
);
    logic [WK_NUM_FLAGS-1:0] flag_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            flag_q <= '0;
        end else begin
            for (int i = 0; i < WK_NUM_FLAGS; i++) begin
                if (clr_all)     flag_q[i] <= 1'b0;
                else if (hit[i]) flag_q[i] <= 1'b1;
                else if (w1c[i]) flag_q[i] <= 1'b0;
            end
        end
    end

    assign flag = flag_q;
endmodule

// File: rtl/wk_rwake_ctl.sv
module wk_rwake_ctl (
    input  logic clk,
    input  logic por_n,
    input  logic cfg_done,
    input  logic pwr_good,
    input  logic magic_act,
    input  logic lcd_mode,
    input  logic magic_flag,
    input  logic link_flag,
    input  logic pol,
    input  logic gate,
    input  logic totem,
    output logic pin_o,
    output logic pin_oe,
    output logic pin_od
);
    logic cfg_known_q;
    logic wake_act;
    logic gated;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)        cfg_known_q <= 1'b0;
        else if (cfg_done) cfg_known_q <= 1'b1;
    end

    assign wake_act = (magic_act && magic_flag) || (lcd_mode && link_flag);
    assign pin_o    = pol ? wake_act : ~wake_act;
    assign gated    = gate && !pwr_good;
    assign pin_od   = ~totem;
    assign pin_oe   = cfg_known_q && !gated && (totem || !pin_o);
endmodule

// File: rtl/wake_pwr_ctl.sv
module wake_pwr_ctl
    import wk_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic pci_rst_n,
    input  logic pwr_good,
    input  logic mp_hit,
    input  logic lc_hit,
    input  logic mp_w1c,
    input  logic lc_w1c,
    input  logic cfg_done,
    input  logic pme_status,
    input  logic pme_en,
    input  logic pme_ovr,
    input  logic mp_en,
    input  logic mp_mode,
    input  logic lcd_mode,
    input  logic rwake_pol,
    input  logic rwake_gate,
    input  logic rwake_totem,
    output logic pme_req,
    output logic rwake_o,
    output logic rwake_oe,
    output logic rwake_od,
    output logic wake_ind,
    output logic int_rst,
    output logic ee_load,
    output logic pci_hiz
);
    logic                    rst_s;
    wk_state_e               state;
    logic [WK_NUM_FLAGS-1:0] flag;
    logic                    magic_act;

    wk_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .por_n (por_n),
        .pin_n (pci_rst_n),
        .rst_s (rst_s)
    );

    wk_mode_fsm u_fsm (
        .clk      (clk),
        .por_n    (por_n),
        .rst_s    (rst_s),
        .pwr_good (pwr_good),
        .cfg_done (cfg_done),
        .state    (state),
        .int_rst  (int_rst),
        .ee_load  (ee_load)
    );

    wk_wake_flags u_flags (
        .clk     (clk),
        .por_n   (por_n),
        .clr_all (int_rst),
        .hit     ({lc_hit, mp_hit}),
        .w1c     ({lc_w1c, mp_w1c}),
        .flag    (flag)
    );

    assign magic_act = !pwr_good && (mp_en || mp_mode);

    wk_rwake_ctl u_rwake (
        .clk        (clk),
        .por_n      (por_n),
        .cfg_done   (cfg_done),
        .pwr_good   (pwr_good),
        .magic_act  (magic_act),
        .lcd_mode   (lcd_mode),
        .magic_flag (flag[WK_FLAG_MAGIC]),
        .link_flag  (flag[WK_FLAG_LINK]),
        .pol        (rwake_pol),
        .gate       (rwake_gate),
        .totem      (rwake_totem),
        .pin_o      (rwake_o),
        .pin_oe     (rwake_oe),
        .pin_od     (rwake_od)
    );

    assign pme_req  = (pme_status && pme_en)
                   || (pme_ovr && flag[WK_FLAG_MAGIC])
                   || (pme_ovr && flag[WK_FLAG_LINK]);
    assign wake_ind = magic_act;
    assign pci_hiz  = rst_s;
endmodule

// File: rtl/wake_pwr_ctl_chk.sv
module wake_pwr_ctl_chk (
    input logic clk,
    input logic por_n,
    input logic pwr_good,
    input logic mp_hit,
    input logic pme_ovr,
    input logic rwake_gate,
    input logic pme_req,
    input logic rwake_o,
    input logic rwake_oe,
    input logic rwake_od,
    input logic wake_ind,
    input logic int_rst,
    input logic ee_load,
    input logic pci_hiz
);
    // R1 and R2: a latched magic hit with the override set requests an event
    assert_hit_raises_pme_R1: assert property (@(posedge clk) disable iff (!por_n)
        ($past(mp_hit) && !$past(int_rst) && pme_ovr) |-> pme_req);

    assert_no_magic_on_main_power_R3: assert property (@(posedge clk) disable iff (!por_n)
        pwr_good |-> !wake_ind);

    assert_reset_release_loads_R4: assert property (@(posedge clk) disable iff (!por_n)
        $fell(int_rst) |-> ee_load);

    assert_aux_reset_ignored_R5: assert property (@(posedge clk) disable iff (!por_n)
        $past(!pwr_good) |-> !int_rst);

    assert_reset_follows_hiz_R6: assert property (@(posedge clk) disable iff (!por_n)
        $rose(int_rst) |-> $past(pci_hiz));

    assert_gate_floats_pin_R9: assert property (@(posedge clk) disable iff (!por_n)
        (rwake_gate && !pwr_good) |-> !rwake_oe);

    assert_open_drain_low_only_R10: assert property (@(posedge clk) disable iff (!por_n)
        (rwake_oe && rwake_od) |-> !rwake_o);
endmodule

bind wake_pwr_ctl wake_pwr_ctl_chk u_chk (
    .clk        (clk),
    .por_n      (por_n),
    .pwr_good   (pwr_good),
    .mp_hit     (mp_hit),
    .pme_ovr    (pme_ovr),
    .rwake_gate (rwake_gate),
    .pme_req    (pme_req),
    .rwake_o    (rwake_o),
    .rwake_oe   (rwake_oe),
    .rwake_od   (rwake_od),
    .wake_ind   (wake_ind),
    .int_rst    (int_rst),
    .ee_load    (ee_load),
    .pci_hiz    (pci_hiz)
);

// File: tb/wake_pwr_ctl_bench.sv
`timescale 1ns/1ps
module wake_pwr_ctl_bench;
    logic clk = 1'b0;
    logic por_n = 1'b0, pci_rst_n = 1'b1, pwr_good = 1'b1;
    logic mp_hit = 1'b0, lc_hit = 1'b0, mp_w1c = 1'b0, lc_w1c = 1'b0, cfg_done = 1'b0;
    logic pme_status = 1'b0, pme_en = 1'b0, pme_ovr = 1'b0;
    logic mp_en = 1'b0, mp_mode = 1'b0, lcd_mode = 1'b0;
    logic rwake_pol = 1'b0, rwake_gate = 1'b0, rwake_totem = 1'b0;
    logic pme_req, rwake_o, rwake_oe, rwake_od, wake_ind, int_rst, ee_load, pci_hiz;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    wake_pwr_ctl u_wake_pwr_ctl (.*);

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // clear both flags, then pulse the requested hits; leaves the bench at the negedge after the hit edge
    task automatic load_flags(input logic fm, input logic fl);
        mp_w1c = 1'b1; lc_w1c = 1'b1;
        cyc(1);
        mp_w1c = 1'b0; lc_w1c = 1'b0;
        mp_hit = fm;   lc_hit = fl;
        cyc(1);
        mp_hit = 1'b0; lc_hit = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        cyc(3);
        // reset state
        chk("R4 reset int_rst", int_rst, 1'b0);
        chk("R4 reset ee_load", ee_load, 1'b1);
        chk("R6 reset pci_hiz", pci_hiz, 1'b0);
        chk("R1 reset pme_req", pme_req, 1'b0);
        chk("R11 reset rwake_oe", rwake_oe, 1'b0);
        por_n = 1'b1;
        rwake_totem = 1'b1;
        cyc(3);
        chk("R11 no oe before cfg_done", rwake_oe, 1'b0);
        cfg_done = 1'b1;
        cyc(1);
        cfg_done = 1'b0;
        chk("R4 load ends on cfg_done", ee_load, 1'b0);
        chk("R11 oe after cfg_done", rwake_oe, 1'b1);

        // R1 sweep over status, enable, override and both flags
        for (int c = 0; c < 32; c++) begin
            pme_status = c[0]; pme_en = c[1]; pme_ovr = c[2];
            load_flags(c[3], c[4]);
            chk("R1 pme sweep", pme_req, (c[0] & c[1]) | (c[2] & (c[3] | c[4])));
        end

        // R2 clearing and set-over-clear priority
        pme_status = 1'b0; pme_en = 1'b0; pme_ovr = 1'b1;
        load_flags(1'b1, 1'b0);
        mp_w1c = 1'b1; cyc(1); mp_w1c = 1'b0;
        chk("R2 magic w1c clears", pme_req, 1'b0);
        load_flags(1'b0, 1'b1);
        lc_w1c = 1'b1; cyc(1); lc_w1c = 1'b0;
        chk("R2 link w1c clears", pme_req, 1'b0);
        mp_hit = 1'b1; mp_w1c = 1'b1; cyc(1); mp_hit = 1'b0; mp_w1c = 1'b0;
        chk("R2 set wins over clear", pme_req, 1'b1);
        cyc(3);
        chk("R2 flag is sticky", pme_req, 1'b1);
        pme_ovr = 1'b0;

        // R3 R7 R8 R9 R10 sweep over pin configuration, power-good, modes and flags
        for (int c = 0; c < 512; c++) begin
            logic mm, act, lvl, oe;
            rwake_pol = c[0]; rwake_gate = c[1]; rwake_totem = c[2];
            pwr_good = c[3]; mp_en = c[4]; mp_mode = c[5]; lcd_mode = c[6];
            load_flags(c[7], c[8]);
            mm  = !c[3] & (c[4] | c[5]);
            act = (mm & c[7]) | (c[6] & c[8]);
            lvl = c[0] ? act : !act;
            oe  = !(c[1] & !c[3]) & (c[2] | !lvl);
            chk("R3 wake_ind", wake_ind, mm);
            chk("R7 R8 rwake level", rwake_o, lvl);
            chk("R9 R10 rwake enable", rwake_oe, oe);
            chk("R10 drive type", rwake_od, !c[2]);
        end

        // R4 R6 reset with main power, exact latency
        pwr_good = 1'b1; mp_en = 1'b0; mp_mode = 1'b0; lcd_mode = 1'b0;
        rwake_gate = 1'b0; rwake_totem = 1'b1;
        pme_ovr = 1'b1;
        load_flags(1'b1, 1'b0);
        chk("R2 flag before reset", pme_req, 1'b1);
        pci_rst_n = 1'b0;
        cyc(1);
        chk("R6 hiz not yet", pci_hiz, 1'b0);
        cyc(1);
        chk("R6 hiz at second edge", pci_hiz, 1'b1);
        chk("R4 int_rst not yet", int_rst, 1'b0);
        cyc(1);
        chk("R4 int_rst at third edge", int_rst, 1'b1);
        chk("R4 no load during reset", ee_load, 1'b0);
        cyc(1);
        chk("R4 flags cleared by reset", pme_req, 1'b0);
        cyc(4);
        chk("R4 reset held", int_rst, 1'b1);
        pci_rst_n = 1'b1;
        cyc(2);
        chk("R6 hiz released", pci_hiz, 1'b0);
        chk("R4 still in reset", int_rst, 1'b1);
        cyc(1);
        chk("R4 reset released", int_rst, 1'b0);
        chk("R4 load after reset", ee_load, 1'b1);
        chk("R11 oe kept after bus reset", rwake_oe, 1'b1);
        cyc(3);
        chk("R4 load waits for cfg_done", ee_load, 1'b1);
        cfg_done = 1'b1; cyc(1); cfg_done = 1'b0;
        chk("R4 load done", ee_load, 1'b0);

        // R5 R6 reset on auxiliary power
        pwr_good = 1'b0;
        load_flags(1'b1, 1'b0);
        pci_rst_n = 1'b0;
        cyc(5);
        chk("R6 hiz on aux power", pci_hiz, 1'b1);
        chk("R5 no int_rst on aux power", int_rst, 1'b0);
        chk("R5 no load on aux power", ee_load, 1'b0);
        chk("R5 flag kept", pme_req, 1'b1);

        // R12 power-good edges while the reset is held
        pwr_good = 1'b1;
        cyc(1);
        chk("R12 power rise enters reset", int_rst, 1'b1);
        cyc(1);
        pwr_good = 1'b0;
        cyc(1);
        chk("R12 power fall leaves reset", int_rst, 1'b0);
        chk("R12 power fall starts load", ee_load, 1'b1);
        cfg_done = 1'b1; cyc(1); cfg_done = 1'b0;
        pci_rst_n = 1'b1;
        cyc(4);
        chk("R5 back to run", ee_load, 1'b0);
        chk("R6 hiz off", pci_hiz, 1'b0);
        chk("R5 no int_rst after release", int_rst, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule